// File: doc/BRIEF.md
# Program Counter Transfer Sequencer

This block holds the 15-bit program counter and the 8-bit stack pointer of a small accumulator machine and performs every change of control flow that the machine can make. A decoder outside the block issues a one-cycle `start` together with a 4-bit transfer code and the operand fields of the instruction. The block then runs the transfer over a fixed number of cycles, with at most one access to each memory per cycle, and raises `done` in the final cycle. The new PC and SP take effect at the clock edge that ends that cycle.

The counter has two parts: a 7-bit upper part and an 8-bit lower part. The supported transfers are:
- plain increment;
- signed relative displacement;
- replacement of the low 12 bits, which stays inside the current 4K segment;
- full 15-bit load;
- a table lookup that replaces only the low byte;
- calls and returns through a byte-wide stack memory;
- a software interrupt;
- vectoring through two adjacent program-memory bytes.

Both memories answer a read one cycle after the address is presented. A call pushes the counter as it stands when the call starts. The decoder must therefore advance the counter past the call instruction, using increment transfers, before it issues the call.

Top module: `pc_xfer_unit`

## Requirements
- R1: While reset is active, and after it is released, `pc` is 0, `sp` is the SP_INIT parameter, and `busy`, `done` and `dmem_we` are 0.
- R2: Transfer codes are 0 step, 1 relative, 2 segment jump, 3 long jump, 4 segment call, 5 long call, 6 table jump, 7 return, 8 return-from-interrupt, 9 return-and-skip, 10 software interrupt and 11 vector. Their lengths in cycles are 1, 3, 3, 4, 5, 5, 3, 5, 5, 5, 7 and 5. An accepted transfer keeps `busy` high for exactly that many cycles and raises `done` only in the last of them. `pc` and `sp` hold their values until the edge that ends the cycle in which `done` is high.
- R3: Step adds 1 to `pc`. Relative adds the sign-extended 7-bit `disp` to all 15 bits of `pc`.
- R4: Segment jump and segment call replace `pc[11:0]` with `seg_addr` and keep `pc[14:12]`.
- R5: Long jump and long call load all of `pc` from `long_addr`.
- R6: Table jump presents `{pc[14:8], acc}` on `pmem_addr` in its first busy cycle. The byte returned becomes `pc[7:0]`, and `pc[14:8]` is unchanged.
- R7: Calls and the software interrupt write `pc[7:0]` to address `sp` in the first busy cycle. In the second busy cycle they write `{1'b0, pc[14:8]}` to address `sp-1`. `sp` is then lowered by 2.
- R8: The three returns read address `sp+2` (which becomes `pc[7:0]`) in the first busy cycle and address `sp+1` (whose low 7 bits become `pc[14:8]`) in the second busy cycle, then raise `sp` by 2. Return-from-interrupt pulses `gie_set` with `done`. Return-and-skip pulses `skip_next` with `done`.
- R9: The software interrupt loads `pc` with 0x0FF after its push.
- R10: Vector reads `vec_addr` in the first busy cycle; the low 7 bits of that byte become `pc[14:8]`. It reads `vec_addr+1` in the second busy cycle; that byte becomes `pc[7:0]`.
- R11: A `start` that arrives while `busy` is high is ignored. Codes 12 to 15 behave as step.
- R12: `pc` arithmetic wraps modulo 2^15, and `sp` arithmetic wraps modulo 2^8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a transfer; sampled only while idle |
| xfer_op | input | 4 | Transfer code |
| disp | input | 7 | Signed relative displacement |
| seg_addr | input | 12 | In-segment target |
| long_addr | input | 15 | Full target |
| acc | input | 8 | Accumulator, low byte of table address |
| vec_addr | input | 15 | Address of the upper vector byte |
| pmem_rdata | input | 8 | Program memory read data, one cycle after address |
| dmem_rdata | input | 8 | Stack memory read data, one cycle after address |
| pmem_addr | output | 15 | Program memory address (the PC when idle) |
| dmem_addr | output | 8 | Stack memory address |
| dmem_wdata | output | 8 | Stack memory write data |
| dmem_we | output | 1 | Stack memory write enable |
| pc | output | 15 | Program counter |
| sp | output | 8 | Stack pointer |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | Last cycle of a transfer |
| gie_set | output | 1 | Pulse: set global interrupt enable |
| skip_next | output | 1 | Pulse: skip the next instruction |

## Verification
A wrong step count shows on the same cycle as a misplaced `done` or memory strobe, because the bench compares `busy`, `done` and the memory strobes on every cycle of every transfer. A bad captured byte or target mux shows on `pc` one edge after `done`. A wrong stack pointer shows immediately on `sp`. A swapped push order or offset surfaces later, when a return brings back a counter different from the one the model recorded. The wrap cases at SP 0x01 and PC 0x7FFE push both pointers across their limits.

// File: rtl/pcx_pkg.sv
package pcx_pkg;

  typedef enum logic [3:0] {
    X_STEP  = 4'd0,
    X_REL   = 4'd1,
    X_JABS  = 4'd2,
    X_JLONG = 4'd3,
    X_CABS  = 4'd4,
    X_CLONG = 4'd5,
    X_JTBL  = 4'd6,
    X_RET   = 4'd7,
    X_RETI  = 4'd8,
    X_RETSK = 4'd9,
    X_SWI   = 4'd10,
    X_VEC   = 4'd11
  } xfer_e;

  localparam int unsigned STEP_W = 3;

  // Map a raw code onto a transfer; unused codes fall back to a step.
  function automatic xfer_e xfer_decode(input logic [3:0] code);
    xfer_e r;
    case (code)
      4'd0:    r = X_STEP;
      4'd1:    r = X_REL;
      4'd2:    r = X_JABS;
      4'd3:    r = X_JLONG;
      4'd4:    r = X_CABS;
      4'd5:    r = X_CLONG;
      4'd6:    r = X_JTBL;
      4'd7:    r = X_RET;
      4'd8:    r = X_RETI;
      4'd9:    r = X_RETSK;
      4'd10:   r = X_SWI;
      4'd11:   r = X_VEC;
      default: r = X_STEP;
    endcase
    return r;
  endfunction

  // Cycle count of each transfer.
  function automatic logic [STEP_W-1:0] xfer_len(input xfer_e op);
    logic [STEP_W-1:0] n;
    case (op)
      X_STEP:  n = 3'd1;
      X_REL:   n = 3'd3;
      X_JABS:  n = 3'd3;
      X_JLONG: n = 3'd4;
      X_CABS:  n = 3'd5;
      X_CLONG: n = 3'd5;
      X_JTBL:  n = 3'd3;
      X_RET:   n = 3'd5;
      X_RETI:  n = 3'd5;
      X_RETSK: n = 3'd5;
      X_SWI:   n = 3'd7;
      X_VEC:   n = 3'd5;
      default: n = 3'd1;
    endcase
    return n;
  endfunction

  function automatic logic is_push(input xfer_e op);
    return (op == X_CABS) || (op == X_CLONG) || (op == X_SWI);
  endfunction

  function automatic logic is_pop(input xfer_e op);
    return (op == X_RET) || (op == X_RETI) || (op == X_RETSK);
  endfunction

endpackage

// File: rtl/pcx_seq.sv
module pcx_seq
  import pcx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        op_code,
  output logic              busy,
  output logic [STEP_W-1:0] step,
  output xfer_e             op_q,
  output logic              accept,
  output logic              last
);

  logic              busy_d;
  logic [STEP_W-1:0] step_d;
  xfer_e             op_d;
  logic [STEP_W-1:0] len;

  always_comb begin
    len    = xfer_len(op_q);
    last   = busy && (step == (len - 3'd1));
    accept = start && !busy;
    op_d   = xfer_decode(op_code);
  end

  always_comb begin
    busy_d = busy;
    step_d = step;
    if (accept) begin
      busy_d = 1'b1;
      step_d = '0;
    end else if (busy) begin
      if (last) begin
        busy_d = 1'b0;
        step_d = '0;
      end else begin
        step_d = step + 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      step <= '0;
    end else begin
      busy <= busy_d;
      step <= step_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= X_STEP;
    end else if (accept) begin
      op_q <= op_d;
    end
  end

endmodule

// File: rtl/pcx_target.sv
module pcx_target
  import pcx_pkg::*;
#(
  parameter int unsigned     PC_W   = 15,
  parameter int unsigned     DW     = 8,
  parameter int unsigned     SEG_W  = 12,
  parameter int unsigned     DISP_W = 7,
  parameter logic [PC_W-1:0] SWI_TARGET = 15'h00FF
) (
  input  xfer_e             op,
  input  logic [PC_W-1:0]   pc,
  input  logic [DISP_W-1:0] disp,
  input  logic [SEG_W-1:0]  seg,
  input  logic [PC_W-1:0]   lng,
  input  logic [DW-1:0]     byte_a,
  input  logic [DW-1:0]     byte_b,
  output logic [PC_W-1:0]   pc_new
);

  localparam int unsigned PU_W = PC_W - DW;

  logic [PC_W-1:0] disp_ext;

  always_comb begin
    disp_ext = {{(PC_W-DISP_W){disp[DISP_W-1]}}, disp};
    case (op)
      X_REL:                      pc_new = pc + disp_ext;
      X_JABS, X_CABS:             pc_new = {pc[PC_W-1:SEG_W], seg};
      X_JLONG, X_CLONG:           pc_new = lng;
      X_JTBL:                     pc_new = {pc[PC_W-1:DW], byte_a};
      X_RET, X_RETI, X_RETSK:     pc_new = {byte_b[PU_W-1:0], byte_a};
      X_SWI:                      pc_new = SWI_TARGET;
      X_VEC:                      pc_new = {byte_a[PU_W-1:0], byte_b};
      default:                    pc_new = pc + PC_W'(1);
    endcase
  end

endmodule

// File: rtl/pcx_stack.sv
module pcx_stack
  import pcx_pkg::*;
#(
  parameter int unsigned PC_W = 15,
  parameter int unsigned DW   = 8
) (
  input  xfer_e             op,
  input  logic              busy,
  input  logic [STEP_W-1:0] step,
  input  logic [DW-1:0]     sp,
  input  logic [PC_W-1:0]   pc,
  output logic [DW-1:0]     addr,
  output logic [DW-1:0]     wdata,
  output logic              we,
  output logic [DW-1:0]     sp_next
);

  always_comb begin
    we      = 1'b0;
    addr    = sp;
    wdata   = '0;
    sp_next = sp;
    if (is_push(op)) begin
      sp_next = sp - DW'(2);
    end else if (is_pop(op)) begin
      sp_next = sp + DW'(2);
    end
    if (busy && is_push(op)) begin
      if (step == 3'd0) begin
        we    = 1'b1;
        wdata = pc[DW-1:0];
      end else if (step == 3'd1) begin
        we    = 1'b1;
        addr  = sp - DW'(1);
        wdata = DW'(pc[PC_W-1:DW]);
      end
    end
    if (busy && is_pop(op)) begin
      if (step == 3'd0) begin
        addr = sp + DW'(2);
      end else if (step == 3'd1) begin
        addr = sp + DW'(1);
      end
    end
  end

endmodule

// File: rtl/pc_xfer_unit.sv
module pc_xfer_unit
  import pcx_pkg::*;
#(
  parameter int unsigned     PC_W       = 15,
  parameter int unsigned     DW         = 8,
  parameter int unsigned     SEG_W      = 12,
  parameter int unsigned     DISP_W     = 7,
  parameter logic [DW-1:0]   SP_INIT    = 8'h6F,
  parameter logic [PC_W-1:0] SWI_TARGET = 15'h00FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        xfer_op,
  input  logic [DISP_W-1:0] disp,
  input  logic [SEG_W-1:0]  seg_addr,
  input  logic [PC_W-1:0]   long_addr,
  input  logic [DW-1:0]     acc,
  input  logic [PC_W-1:0]   vec_addr,
  input  logic [DW-1:0]     pmem_rdata,
  input  logic [DW-1:0]     dmem_rdata,
  output logic [PC_W-1:0]   pmem_addr,
  output logic [DW-1:0]     dmem_addr,
  output logic [DW-1:0]     dmem_wdata,
  output logic              dmem_we,
  output logic [PC_W-1:0]   pc,
  output logic [DW-1:0]     sp,
  output logic              busy,
  output logic              done,
  output logic              gie_set,
  output logic              skip_next
);

  // Reset: asserted at once, released after two clock edges.
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  xfer_e             op_q;
  logic [STEP_W-1:0] step;
  logic              accept;
  logic              last;
  logic              busy_i;

  pcx_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start   (start),
    .op_code (xfer_op),
    .busy    (busy_i),
    .step    (step),
    .op_q    (op_q),
    .accept  (accept),
    .last    (last)
  );

  // Operands held for the whole transfer.
  logic [DISP_W-1:0] disp_q;
  logic [SEG_W-1:0]  seg_q;
  logic [PC_W-1:0]   lng_q;
  logic [DW-1:0]     acc_q;
  logic [PC_W-1:0]   vec_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      disp_q <= '0;
      seg_q  <= '0;
      lng_q  <= '0;
      acc_q  <= '0;
      vec_q  <= '0;
    end else if (accept) begin
      disp_q <= disp;
      seg_q  <= seg_addr;
      lng_q  <= long_addr;
      acc_q  <= acc;
      vec_q  <= vec_addr;
    end
  end

  // Bytes returned by either memory, captured one cycle after each read.
  logic          reads_mem;
  logic [DW-1:0] rd_byte;
  logic          cap_a;
  logic          cap_b;
  logic [DW-1:0] byte_a;
  logic [DW-1:0] byte_b;

  always_comb begin
    reads_mem = is_pop(op_q) || (op_q == X_JTBL) || (op_q == X_VEC);
    rd_byte   = is_pop(op_q) ? dmem_rdata : pmem_rdata;
    cap_a     = busy_i && reads_mem && (step == 3'd1);
    cap_b     = busy_i && reads_mem && (step == 3'd2);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      byte_a <= '0;
    end else if (cap_a) begin
      byte_a <= rd_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      byte_b <= '0;
    end else if (cap_b) begin
      byte_b <= rd_byte;
    end
  end

  logic [PC_W-1:0] pc_q;
  logic [DW-1:0]   sp_q;
  logic [PC_W-1:0] pc_new;
  logic [DW-1:0]   sp_new;

  pcx_target #(
    .PC_W       (PC_W),
    .DW         (DW),
    .SEG_W      (SEG_W),
    .DISP_W     (DISP_W),
    .SWI_TARGET (SWI_TARGET)
  ) u_target (
    .op     (op_q),
    .pc     (pc_q),
    .disp   (disp_q),
    .seg    (seg_q),
    .lng    (lng_q),
    .byte_a (byte_a),
    .byte_b (byte_b),
    .pc_new (pc_new)
  );

  pcx_stack #(
    .PC_W (PC_W),
    .DW   (DW)
  ) u_stack (
    .op      (op_q),
    .busy    (busy_i),
    .step    (step),
    .sp      (sp_q),
    .pc      (pc_q),
    .addr    (dmem_addr),
    .wdata   (dmem_wdata),
    .we      (dmem_we),
    .sp_next (sp_new)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pc_q <= '0;
      sp_q <= SP_INIT;
    end else if (last) begin
      pc_q <= pc_new;
      sp_q <= sp_new;
    end
  end

  // Program memory address: fetch address unless a transfer reads a table.
  always_comb begin
    pmem_addr = pc_q;
    if (busy_i && (op_q == X_JTBL) && (step == 3'd0)) begin
      pmem_addr = {pc_q[PC_W-1:DW], acc_q};
    end else if (busy_i && (op_q == X_VEC)) begin
      if (step == 3'd0)      pmem_addr = vec_q;
      else if (step == 3'd1) pmem_addr = vec_q + PC_W'(1);
    end
  end

  assign pc        = pc_q;
  assign sp        = sp_q;
  assign busy      = busy_i;
  assign done      = last;
  assign gie_set   = last && (op_q == X_RETI);
  assign skip_next = last && (op_q == X_RETSK);

endmodule

// File: rtl/pcx_checker.sv
module pcx_checker
  import pcx_pkg::*;
#(
  parameter int unsigned     PC_W       = 15,
  parameter int unsigned     DW         = 8,
  parameter int unsigned     SEG_W      = 12,
  parameter logic [PC_W-1:0] SWI_TARGET = 15'h00FF
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            dmem_we,
  input logic            gie_set,
  input logic            skip_next,
  input logic [PC_W-1:0] pc,
  input logic [PC_W-1:0] pmem_addr,
  input logic [DW-1:0]   sp,
  input xfer_e           op_q
);

  p_done_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  p_hold_mid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> ($stable(pc) && $stable(sp)));

  p_seg_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ((op_q == X_JABS) || (op_q == X_CABS)))
      |=> (pc[PC_W-1:SEG_W] == $past(pc[PC_W-1:SEG_W])));

  p_push_sp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ((op_q == X_CABS) || (op_q == X_CLONG) || (op_q == X_SWI)))
      |=> (sp == $past(sp) - DW'(2)));

  p_pop_sp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ((op_q == X_RET) || (op_q == X_RETI) || (op_q == X_RETSK)))
      |=> (sp == $past(sp) + DW'(2)));

  p_gie_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gie_set |-> (done && (op_q == X_RETI)));

  p_skip_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    skip_next |-> (done && (op_q == X_RETSK)));

  p_swi_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (op_q == X_SWI)) |=> (pc == SWI_TARGET));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!dmem_we && (pmem_addr == pc)));

endmodule

bind pc_xfer_unit pcx_checker #(
  .PC_W       (PC_W),
  .DW         (DW),
  .SEG_W      (SEG_W),
  .SWI_TARGET (SWI_TARGET)
) u_pcx_checker (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .busy      (busy),
  .done      (done),
  .dmem_we   (dmem_we),
  .gie_set   (gie_set),
  .skip_next (skip_next),
  .pc        (pc),
  .pmem_addr (pmem_addr),
  .sp        (sp),
  .op_q      (op_q)
);

// File: tb/tb_pc_xfer_unit.sv
`timescale 1ns/1ps
module tb_pc_xfer_unit;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [3:0]  xfer_op;
  logic [6:0]  disp;
  logic [11:0] seg_addr;
  logic [14:0] long_addr;
  logic [7:0]  acc;
  logic [14:0] vec_addr;
  logic [7:0]  pmem_rdata;
  logic [7:0]  dmem_rdata;
  logic [14:0] pmem_addr;
  logic [7:0]  dmem_addr;
  logic [7:0]  dmem_wdata;
  logic        dmem_we;
  logic [14:0] pc;
  logic [7:0]  sp;
  logic        busy;
  logic        done;
  logic        gie_set;
  logic        skip_next;

  int tests;
  int fails;

  pc_xfer_unit #(.SP_INIT(8'h01)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .xfer_op(xfer_op),
    .disp(disp), .seg_addr(seg_addr), .long_addr(long_addr), .acc(acc),
    .vec_addr(vec_addr), .pmem_rdata(pmem_rdata), .dmem_rdata(dmem_rdata),
    .pmem_addr(pmem_addr), .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .dmem_we(dmem_we), .pc(pc), .sp(sp), .busy(busy), .done(done),
    .gie_set(gie_set), .skip_next(skip_next)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Program memory contents are a fixed function of the address.
  function automatic logic [7:0] pf(input logic [14:0] a);
    logic [7:0] t;
    t = a[7:0] * 8'd13;
    return t ^ {1'b0, a[14:8]} ^ 8'hA5;
  endfunction

  logic [7:0] dmem [0:255];
  logic [7:0] mmem [0:255];

  always @(posedge clk) begin
    pmem_rdata <= pf(pmem_addr);
    dmem_rdata <= dmem[dmem_addr];
    if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
  end

  int mpc;
  int msp;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int op_len(input int c);
    case (c)
      0: return 1;  1: return 3;  2: return 3;  3: return 4;
      4: return 5;  5: return 5;  6: return 3;  7: return 5;
      8: return 5;  9: return 5;  10: return 7; 11: return 5;
      default: return 1;
    endcase
  endfunction

  task automatic run(input logic [3:0] code, input bit poke, input string req);
    int eff, len, npc, nsp, d, pu, pl;
    bit push, pop;
    eff  = (code > 4'd11) ? 0 : int'(code);
    len  = op_len(eff);
    push = (eff == 4) || (eff == 5) || (eff == 10);
    pop  = (eff == 7) || (eff == 8) || (eff == 9);
    d    = int'($signed(disp));
    nsp  = msp;
    case (eff)
      1:       npc = (mpc + d) & 32'h7FFF;
      2, 4:    npc = (mpc & 32'h7000) | int'(seg_addr);
      3, 5:    npc = int'(long_addr);
      6:       npc = (mpc & 32'h7F00) | int'(pf(15'((mpc & 32'h7F00) | int'(acc))));
      7, 8, 9: begin
        pl  = int'(mmem[(msp + 2) & 255]);
        pu  = int'(mmem[(msp + 1) & 255]) & 32'h7F;
        npc = (pu << 8) | pl;
        nsp = (msp + 2) & 255;
      end
      10:      npc = 32'h00FF;
      11: begin
        pu  = int'(pf(vec_addr)) & 32'h7F;
        pl  = int'(pf(15'((int'(vec_addr) + 1) & 32'h7FFF)));
        npc = (pu << 8) | pl;
      end
      default: npc = (mpc + 1) & 32'h7FFF;
    endcase
    if (push) begin
      mmem[msp & 255]       = 8'(mpc & 255);
      mmem[(msp - 1) & 255] = 8'((mpc >> 8) & 32'h7F);
      nsp = (msp - 2) & 255;
    end

    xfer_op = code;
    start   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < len; k++) begin
      chk("R2", "busy", busy, 1);
      chk("R2", "done", done, (k == len - 1));
      chk("R2", "pc held", pc, mpc);
      chk("R8", "gie_set", gie_set, (eff == 8) && (k == len - 1));
      chk("R8", "skip_next", skip_next, (eff == 9) && (k == len - 1));
      if (push && k == 0) begin
        chk("R7", "we0", dmem_we, 1);
        chk("R7", "addr0", dmem_addr, msp & 255);
        chk("R7", "low byte", dmem_wdata, mpc & 255);
      end else if (push && k == 1) begin
        chk("R7", "we1", dmem_we, 1);
        chk("R7", "addr1", dmem_addr, (msp - 1) & 255);
        chk("R7", "high byte", dmem_wdata, (mpc >> 8) & 32'h7F);
      end else begin
        chk("R7", "no write", dmem_we, 0);
      end
      if (pop && k == 0) chk("R8", "read lo addr", dmem_addr, (msp + 2) & 255);
      if (pop && k == 1) chk("R8", "read hi addr", dmem_addr, (msp + 1) & 255);
      if (eff == 6 && k == 0) chk("R6", "table addr", pmem_addr, (mpc & 32'h7F00) | int'(acc));
      if (eff == 11 && k == 0) chk("R10", "vec addr0", pmem_addr, vec_addr);
      if (eff == 11 && k == 1) chk("R10", "vec addr1", pmem_addr, (int'(vec_addr) + 1) & 32'h7FFF);
      if (poke && k == 1) begin
        start     = 1'b1;
        xfer_op   = 4'd3;
        long_addr = 15'h7777;
      end
      if (poke && k == 2) start = 1'b0;
      @(negedge clk);
    end
    chk(req, "pc", pc, npc);
    chk(req, "sp", sp, nsp);
    chk("R2", "idle after", busy, 0);
    if (poke) chk("R11", "start while busy ignored", busy, 0);
    mpc = npc;
    msp = nsp;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tests = 0;
    fails = 0;
    for (int i = 0; i < 256; i++) begin
      dmem[i] = 8'(i) ^ 8'h5A;
      mmem[i] = 8'(i) ^ 8'h5A;
    end
    rst_n = 1'b0;
    start = 1'b0;
    xfer_op = '0; disp = '0; seg_addr = '0; long_addr = '0;
    acc = '0; vec_addr = '0;
    repeat (3) @(negedge clk);
    chk("R1", "reset pc", pc, 0);
    chk("R1", "reset sp", sp, 8'h01);
    chk("R1", "reset busy", busy, 0);
    chk("R1", "reset done", done, 0);
    chk("R1", "reset we", dmem_we, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "post reset pc", pc, 0);
    chk("R1", "post reset sp", sp, 8'h01);
    mpc = 0;
    msp = 1;

    run(4'd0, 0, "R3");                                 // step
    long_addr = 15'h1234; run(4'd3, 0, "R5");           // long jump
    disp = 7'd32;         run(4'd1, 0, "R3");           // +32
    disp = 7'h61;         run(4'd1, 0, "R3");           // -31
    seg_addr = 12'hABC;   run(4'd2, 0, "R4");           // segment jump
    acc = 8'h37;          run(4'd6, 0, "R6");           // table jump
    seg_addr = 12'h456;   run(4'd4, 0, "R4");           // segment call, sp wraps (R12)
    long_addr = 15'h7FFE; run(4'd5, 1, "R5");           // long call with ignored start
    disp = 7'd5;          run(4'd1, 0, "R12");          // pc wraps past 0x7FFF
    run(4'd14, 0, "R11");                               // unused code acts as step
    run(4'd7, 0, "R8");                                 // return
    run(4'd9, 0, "R8");                                 // return and skip
    run(4'd10, 1, "R9");                                // software interrupt
    run(4'd8, 0, "R8");                                 // return from interrupt
    vec_addr = 15'h0010;  run(4'd11, 0, "R10");         // vector
    vec_addr = 15'h7FFF;  run(4'd11, 0, "R10");         // vector pair wraps
    run(4'd7, 0, "R12");                                // return reads preset bytes

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule